// File: doc/BRIEF.md
# Configuration Access Sequencer

This block takes one configuration-space read or write request and turns it into an ordered series of bus transfers on a simple register port. A request names a target bus, a device/function number, a byte offset and an access size of one, two or four bytes, plus the write data. The sequencer first loads an address register with a formatted target word. It then moves the data through a data window and finally writes zero back to the address register. After that it returns the status and, for reads, the result aligned to bit 0.

Requests to bus 0 always move whole 32-bit words through the window. A partial write on bus 0 therefore becomes a read, a lane merge and a write-back. Requests to any other bus use narrow transfers only. A one-byte access touches one byte lane and a two-byte access touches one halfword. A four-byte access is split into two halfword transfers, the lower half first. A request flagged as excluded completes at once with a device-not-found status and produces no bus traffic.

Top module: `cfgx_sequencer`

## Requirements
- R1: After reset, req_ready is high, and busy, done and mst_valid are low. A request is taken when req_valid and req_ready are both high at a clock edge. busy is high from the next cycle through the single cycle in which done is high, and req_ready is low for that whole time.
- R2: A request taken with req_exclude high produces no transfer on the mst_* port. It raises done in the cycle after acceptance, with rsp_status = 1 and rsp_rdata = 0.
- R3: The first transfer of any request that is not excluded writes the address register (mst_win = 0, mst_be = 4'b1111). The address value has bit 31 = 1, bits 30:24 = 0, bus in bits 23:16, device/function in bits 15:8, offset bits 7:2 in bits 7:2 and bits 1:0 = 0. It is sent most significant byte first: value bits 31:24 appear on mst_wdata[7:0].
- R4: The last transfer before done writes zero to the address register. done is raised in the cycle after that transfer completes, with rsp_status = 0. rsp_rdata is 0 for writes.
- R5: On bus 0, a 1- or 2-byte read performs one full-word read of the data window (mst_win = 1, mst_be = 4'b1111). The result is the word shifted right by 8 × (offset mod 4) and masked to 8 or 16 bits.
- R6: On bus 0, a 1- or 2-byte write performs a full-word read and then a full-word write. The written word keeps the lanes outside (size mask << 8 × (offset mod 4)) and takes the shifted write data inside it.
- R7: On bus 0, a 4-byte write is one full-word write with no read, and a 4-byte read is one full-word read returned unshifted. The window is little-endian: value bits 7:0 sit on mst_wdata[7:0] / mst_rdata[7:0].
- R8: On a non-zero bus, a 1-byte access is one transfer with mst_be = 1 << offset[1:0]. The data sits in that byte lane.
- R9: On a non-zero bus, a 2-byte access is one transfer with mst_be = 4'b0011 when offset bit 1 is 0 and 4'b1100 when it is 1. The data sits in that halfword.
- R10: On a non-zero bus, a 4-byte access is two transfers, mst_be = 4'b0011 then 4'b1100. A read result takes bits 15:0 from the first transfer and bits 31:16 from the second.
- R11: req_size encodes 0 as one byte, 1 as two bytes, and both 2 and 3 as four bytes.
- R12: While mst_valid is high and mst_ready is low, mst_valid stays high and mst_write, mst_win, mst_be and mst_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_exclude | input | 1 | Target is excluded; answer device-not-found |
| req_bus | input | BUS_W | Target bus number |
| req_devfn | input | DEVFN_W | Target device/function |
| req_off | input | OFF_W | Register byte offset |
| req_size | input | 2 | Access size code (R11) |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 1 | 0 = success, 1 = device not found |
| rsp_rdata | output | 32 | Read result, valid with done |
| mst_valid | output | 1 | Transfer request on the register port |
| mst_ready | input | 1 | Transfer completes at this edge |
| mst_write | output | 1 | Transfer direction |
| mst_win | output | 1 | 0 = address register, 1 = data window |
| mst_be | output | 4 | Byte enables |
| mst_wdata | output | 32 | Transfer write data |
| mst_rdata | input | 32 | Read data, sampled when the transfer completes |

## Verification
The most exposed coincidence is a new request standing at the inputs during the completion cycle of the previous one. The bench drives requests back to back with req_valid kept high, so each request is already present in the cycle where done pulses. It judges this in two ways. First, req_ready must read low at that sample. Second, the scoreboard must see the next address-register write only after the clear write and the response, never merged into the previous sequence. A second coincidence is a transfer that completes in the same edge as the sequence moves on. Random stalls on mst_ready cover this: a completion that is dropped or repeated surfaces as a mismatch against the queued transfer list.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   localparam int WORD_W = 32;
   localparam int LANES  = WORD_W / 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA_A,
      ST_DATA_B,
      ST_CLEAR,
      ST_RESP
   } cfgx_state_e;

   typedef enum logic {
      STS_OK    = 1'b0,
      STS_NODEV = 1'b1
   } cfgx_status_e;

   // byte-enable vector to a bit mask over the word
   function automatic logic [WORD_W-1:0] expand_be(input logic [LANES-1:0] be);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int i = 0; i < LANES; i++) begin
         m[8*i +: 8] = {8{be[i]}};
      end
      return m;
   endfunction

   // right-aligned mask for a size code
   function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] sz);
      logic [WORD_W-1:0] m;
      case (sz)
         2'd0:    m = 32'h0000_00FF;
         2'd1:    m = 32'h0000_FFFF;
         default: m = '1;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/cfgx_addr_fmt.sv
module cfgx_addr_fmt
   import cfgx_pkg::*;
#(
   parameter int BUS_W   = 8,
   parameter int DEVFN_W = 8,
   parameter int OFF_W   = 8
) (
   input  logic [BUS_W-1:0]   tgt_bus,
   input  logic [DEVFN_W-1:0] tgt_devfn,
   input  logic [OFF_W-1:0]   tgt_off,
   output logic [WORD_W-1:0]  addr_word,
   output logic [WORD_W-1:0]  addr_image
);

   localparam int FIELD_W = 8;

   if (BUS_W < 1 || BUS_W > FIELD_W) begin : g_bad_bus
      $error("cfgx_addr_fmt: BUS_W must lie in 1..8");
   end
   if (DEVFN_W < 1 || DEVFN_W > FIELD_W) begin : g_bad_devfn
      $error("cfgx_addr_fmt: DEVFN_W must lie in 1..8");
   end
   if (OFF_W < 2 || OFF_W > FIELD_W) begin : g_bad_off
      $error("cfgx_addr_fmt: OFF_W must lie in 2..8");
   end

   logic [FIELD_W-1:0] bus_f;
   logic [FIELD_W-1:0] devfn_f;
   logic [FIELD_W-1:0] off_f;

   assign bus_f   = FIELD_W'(tgt_bus);
   assign devfn_f = FIELD_W'(tgt_devfn);
   assign off_f   = FIELD_W'(tgt_off);

   // enable | bus | devfn | dword-aligned offset
   assign addr_word = {1'b1, 7'b0, bus_f, devfn_f, off_f[FIELD_W-1:2], 2'b00};

   // the address register takes the most significant byte at the lowest lane
   for (genvar g = 0; g < LANES; g++) begin : g_swap
      assign addr_image[8*g +: 8] = addr_word[8*(LANES-1-g) +: 8];
   end

endmodule

// File: rtl/cfgx_lane_unit.sv
module cfgx_lane_unit
   import cfgx_pkg::*;
(
   input  logic [1:0]        size,
   input  logic [1:0]        off_lo,
   input  logic              split,
   input  logic              phase_b,
   input  logic [WORD_W-1:0] raw,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rd_value,
   output logic [WORD_W-1:0] merge_word,
   output logic [WORD_W-1:0] narrow_data,
   output logic [LANES-1:0]  narrow_be
);

   localparam logic [LANES-1:0] LO_BE = {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}};
   localparam logic [LANES-1:0] HI_BE = ~LO_BE;

   logic              wide;
   logic [1:0]        sh;
   logic [4:0]        bit_sh;
   logic [WORD_W-1:0] len_m;
   logic [WORD_W-1:0] placed_m;
   logic [LANES-1:0]  base_be;

   assign wide = size[1];

   // lane shift: none for words, halfword-aligned for split halves,
   // raw byte offset otherwise
   always_comb begin
      if (wide) begin
         sh = 2'd0;
      end else if (split && size == 2'd1) begin
         sh = {off_lo[1], 1'b0};
      end else begin
         sh = off_lo;
      end
   end

   assign bit_sh   = {sh, 3'b000};
   assign len_m    = size_mask(size);
   assign placed_m = len_m << bit_sh;

   assign rd_value    = (raw >> bit_sh) & len_m;
   assign merge_word  = (raw & ~placed_m) | ((wdata << bit_sh) & placed_m);
   assign narrow_data = wdata << bit_sh;

   always_comb begin
      case (size)
         2'd0:    base_be = LANES'(1);
         2'd1:    base_be = LANES'(3);
         default: base_be = phase_b ? HI_BE : LO_BE;
      endcase
   end

   assign narrow_be = wide ? base_be : (base_be << sh);

endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
   import cfgx_pkg::*;
#(
   parameter int BUS_W   = 8,
   parameter int DEVFN_W = 8,
   parameter int OFF_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic               req_exclude,
   input  logic [BUS_W-1:0]   req_bus,
   input  logic [DEVFN_W-1:0] req_devfn,
   input  logic [OFF_W-1:0]   req_off,
   input  logic [1:0]         req_size,
   input  logic [WORD_W-1:0]  req_wdata,
   input  logic               split,
   input  logic [WORD_W-1:0]  addr_image,
   input  logic [WORD_W-1:0]  merge_word,
   input  logic [WORD_W-1:0]  narrow_data,
   input  logic [LANES-1:0]   narrow_be,
   output logic [BUS_W-1:0]   r_bus,
   output logic [DEVFN_W-1:0] r_devfn,
   output logic [OFF_W-1:0]   r_off,
   output logic [1:0]         r_size,
   output logic               r_write,
   output logic [WORD_W-1:0]  r_wdata,
   output logic [WORD_W-1:0]  raw,
   output logic               phase_b,
   output logic               busy,
   output logic               done,
   output logic               status,
   output logic               mst_valid,
   input  logic               mst_ready,
   output logic               mst_write,
   output logic               mst_win,
   output logic [LANES-1:0]   mst_be,
   output logic [WORD_W-1:0]  mst_wdata,
   input  logic [WORD_W-1:0]  mst_rdata
);

   cfgx_state_e  state, nxt;
   cfgx_status_e sts_q;
   logic         accept;
   logic         xfer;
   logic         direct_rmw;
   logic         two_data;

   assign accept     = (state == ST_IDLE) && req_valid;
   assign xfer       = mst_valid && mst_ready;
   assign direct_rmw = !split && r_write && !r_size[1];
   assign two_data   = (split && r_size[1]) || direct_rmw;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:   if (accept) nxt = req_exclude ? ST_RESP : ST_ADDR;
         ST_ADDR:   if (xfer) nxt = ST_DATA_A;
         ST_DATA_A: if (xfer) nxt = two_data ? ST_DATA_B : ST_CLEAR;
         ST_DATA_B: if (xfer) nxt = ST_CLEAR;
         ST_CLEAR:  if (xfer) nxt = ST_RESP;
         ST_RESP:   nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         sts_q   <= STS_OK;
         r_bus   <= '0;
         r_devfn <= '0;
         r_off   <= '0;
         r_size  <= '0;
         r_write <= 1'b0;
         r_wdata <= '0;
         raw     <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            sts_q   <= req_exclude ? STS_NODEV : STS_OK;
            r_bus   <= req_bus;
            r_devfn <= req_devfn;
            r_off   <= req_off;
            r_size  <= req_size;
            r_write <= req_write;
            r_wdata <= req_wdata;
            raw     <= '0;
         end else if (xfer && mst_win && !mst_write) begin
            raw <= (raw & ~expand_be(mst_be)) | (mst_rdata & expand_be(mst_be));
         end
      end
   end

   // transfer selection per phase
   always_comb begin
      mst_valid = 1'b0;
      mst_write = 1'b0;
      mst_win   = 1'b0;
      mst_be    = '1;
      mst_wdata = '0;
      case (state)
         ST_ADDR: begin
            mst_valid = 1'b1;
            mst_write = 1'b1;
            mst_wdata = addr_image;
         end
         ST_DATA_A: begin
            mst_valid = 1'b1;
            mst_win   = 1'b1;
            if (split) begin
               mst_write = r_write;
               mst_be    = narrow_be;
               mst_wdata = narrow_data;
            end else begin
               mst_write = r_write && r_size[1];
               mst_wdata = r_wdata;
            end
         end
         ST_DATA_B: begin
            mst_valid = 1'b1;
            mst_win   = 1'b1;
            if (split) begin
               mst_write = r_write;
               mst_be    = narrow_be;
               mst_wdata = narrow_data;
            end else begin
               mst_write = 1'b1;
               mst_wdata = merge_word;
            end
         end
         ST_CLEAR: begin
            mst_valid = 1'b1;
            mst_write = 1'b1;
         end
         default: ;
      endcase
   end

   assign phase_b   = (state == ST_DATA_B);
   assign req_ready = (state == ST_IDLE);
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_RESP);
   assign status    = sts_q;

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy); // R1
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy)); // R1
   AST_EXCL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_exclude) |=> (done && !mst_valid)); // R2
   AST_CLEAR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == STS_OK) |->
         $past(mst_valid && mst_ready && mst_write && !mst_win && mst_wdata == '0)); // R4
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_valid && !mst_ready) |=> (mst_valid && $stable(mst_write) && $stable(mst_win)
                                     && $stable(mst_be) && $stable(mst_wdata))); // R12

endmodule

// File: rtl/cfgx_sequencer.sv
module cfgx_sequencer
   import cfgx_pkg::*;
#(
   parameter int BUS_W    = 8,
   parameter int DEVFN_W  = 8,
   parameter int OFF_W    = 8,
   parameter bit SPLIT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic               req_exclude,
   input  logic [BUS_W-1:0]   req_bus,
   input  logic [DEVFN_W-1:0] req_devfn,
   input  logic [OFF_W-1:0]   req_off,
   input  logic [1:0]         req_size,
   input  logic [31:0]        req_wdata,
   output logic               busy,
   output logic               done,
   output logic               rsp_status,
   output logic [31:0]        rsp_rdata,
   output logic               mst_valid,
   input  logic               mst_ready,
   output logic               mst_write,
   output logic               mst_win,
   output logic [3:0]         mst_be,
   output logic [31:0]        mst_wdata,
   input  logic [31:0]        mst_rdata
);

   if (WORD_W != 32 || LANES != 4) begin : g_bad_word
      $error("cfgx_sequencer: the data window must be 32 bits wide");
   end

   logic [BUS_W-1:0]   r_bus;
   logic [DEVFN_W-1:0] r_devfn;
   logic [OFF_W-1:0]   r_off;
   logic [1:0]         r_size;
   logic               r_write;
   logic [WORD_W-1:0]  r_wdata;
   logic [WORD_W-1:0]  raw;
   logic               phase_b;
   logic               split;
   logic [WORD_W-1:0]  addr_word;
   logic [WORD_W-1:0]  addr_image;
   logic [WORD_W-1:0]  rd_value;
   logic [WORD_W-1:0]  merge_word;
   logic [WORD_W-1:0]  narrow_data;
   logic [LANES-1:0]   narrow_be;

   // narrow transfers apply to any bus other than 0 when enabled
   if (SPLIT_EN) begin : g_split
      assign split = |r_bus;
   end else begin : g_flat
      assign split = 1'b0;
   end

   cfgx_addr_fmt #(
      .BUS_W   (BUS_W),
      .DEVFN_W (DEVFN_W),
      .OFF_W   (OFF_W)
   ) u_addr (
      .tgt_bus    (r_bus),
      .tgt_devfn  (r_devfn),
      .tgt_off    (r_off),
      .addr_word  (addr_word),
      .addr_image (addr_image)
   );

   cfgx_lane_unit u_lane (
      .size        (r_size),
      .off_lo      (r_off[1:0]),
      .split       (split),
      .phase_b     (phase_b),
      .raw         (raw),
      .wdata       (r_wdata),
      .rd_value    (rd_value),
      .merge_word  (merge_word),
      .narrow_data (narrow_data),
      .narrow_be   (narrow_be)
   );

   cfgx_ctrl #(
      .BUS_W   (BUS_W),
      .DEVFN_W (DEVFN_W),
      .OFF_W   (OFF_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_write   (req_write),
      .req_exclude (req_exclude),
      .req_bus     (req_bus),
      .req_devfn   (req_devfn),
      .req_off     (req_off),
      .req_size    (req_size),
      .req_wdata   (req_wdata),
      .split       (split),
      .addr_image  (addr_image),
      .merge_word  (merge_word),
      .narrow_data (narrow_data),
      .narrow_be   (narrow_be),
      .r_bus       (r_bus),
      .r_devfn     (r_devfn),
      .r_off       (r_off),
      .r_size      (r_size),
      .r_write     (r_write),
      .r_wdata     (r_wdata),
      .raw         (raw),
      .phase_b     (phase_b),
      .busy        (busy),
      .done        (done),
      .status      (rsp_status),
      .mst_valid   (mst_valid),
      .mst_ready   (mst_ready),
      .mst_write   (mst_write),
      .mst_win     (mst_win),
      .mst_be      (mst_be),
      .mst_wdata   (mst_wdata),
      .mst_rdata   (mst_rdata)
   );

   assign rsp_rdata = (done && !r_write && rsp_status == STS_OK) ? rd_value : '0;

   AST_ADDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_exclude) |=>
         (mst_valid && mst_write && !mst_win && mst_wdata[7:0] == 8'h80)); // R3
   AST_DIRECT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_valid && mst_win && !split) |-> (mst_be == 4'b1111)); // R5
   AST_SPLIT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_valid && mst_win && split && r_size == 2'd0) |-> ($countones(mst_be) == 1)); // R8
   AST_SPLIT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_valid && mst_win && split && r_size != 2'd0) |->
         (mst_be == 4'b0011 || mst_be == 4'b1100)); // R10

endmodule

// File: tb/cfgx_sequencer_test.sv
`timescale 1ns/1ps
module cfgx_sequencer_test;

   typedef struct packed {
      logic        win;
      logic        wr;
      logic [3:0]  be;
      logic [31:0] data;
   } txn_t;

   typedef struct packed {
      logic        sts;
      logic [31:0] data;
   } rsp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_exclude = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [7:0]  req_devfn = '0;
   logic [7:0]  req_off = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, busy, done, rsp_status;
   logic [31:0] rsp_rdata;
   logic        mst_valid, mst_write, mst_win;
   logic [3:0]  mst_be;
   logic [31:0] mst_wdata;
   logic        mst_ready = 1'b0;
   logic [31:0] mst_rdata = '0;

   always #4 clk = ~clk;

   cfgx_sequencer uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_exclude(req_exclude), .req_bus(req_bus), .req_devfn(req_devfn),
      .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
      .mst_valid(mst_valid), .mst_ready(mst_ready), .mst_write(mst_write),
      .mst_win(mst_win), .mst_be(mst_be), .mst_wdata(mst_wdata), .mst_rdata(mst_rdata)
   );

   txn_t  exp_q[$];
   string ttag_q[$];
   rsp_t  rsp_q[$];
   string rtag_q[$];
   int    checks = 0;
   int    fails = 0;
   bit    stall_on = 1'b0;
   bit    finished = 1'b0;
   logic [31:0] slave_addr = '0;
   txn_t  got_t, exp_t;
   rsp_t  got_r, exp_r;
   string cur_tag;

   function automatic logic [31:0] bswap(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   function automatic logic [31:0] cfgw(input logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'h3C5A_E196;
   endfunction

   function automatic logic [31:0] bemask(input logic [3:0] be);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
      return m;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push_t(input logic win, input logic wr, input logic [3:0] be,
                         input logic [31:0] d, input string tag);
      txn_t t;
      t.win = win; t.wr = wr; t.be = be; t.data = wr ? (d & bemask(be)) : 32'h0;
      exp_q.push_back(t);
      ttag_q.push_back(tag);
   endtask

   // driver: predicts transfers and response, then presents the request
   task automatic issue(input bit wr, input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [7:0] off, input logic [1:0] sz, input logic [31:0] wd,
                        input bit ex, input string tag);
      logic [31:0] a, w, m, pm, rd;
      logic [4:0]  bs;
      logic [3:0]  be;
      rsp_t r;
      a  = {1'b1, 7'b0, bus, devfn, off[7:2], 2'b00};
      w  = cfgw(a);
      m  = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
      rd = 32'h0;
      if (ex) begin
         r.sts = 1'b1; r.data = 32'h0;
      end else begin
         push_t(1'b0, 1'b1, 4'hF, bswap(a), {tag, " R3 address write"});
         if (bus == 8'd0) begin
            bs = {off[1:0], 3'b000};
            if (sz[1]) begin
               push_t(1'b1, wr, 4'hF, wd, {tag, " R7 word transfer"});
               rd = w;
            end else if (!wr) begin
               push_t(1'b1, 1'b0, 4'hF, 32'h0, {tag, " R5 word read"});
               rd = (w >> bs) & m;
            end else begin
               pm = m << bs;
               push_t(1'b1, 1'b0, 4'hF, 32'h0, {tag, " R6 merge read"});
               push_t(1'b1, 1'b1, 4'hF, (w & ~pm) | ((wd << bs) & pm), {tag, " R6 merge write"});
            end
         end else begin
            if (sz == 2'd0) begin
               bs = {off[1:0], 3'b000};
               be = 4'b0001 << off[1:0];
               push_t(1'b1, wr, be, wd << bs, {tag, " R8 byte lane"});
               rd = (w >> bs) & m;
            end else if (sz == 2'd1) begin
               bs = {off[1], 4'b0000};
               be = off[1] ? 4'b1100 : 4'b0011;
               push_t(1'b1, wr, be, wd << bs, {tag, " R9 halfword"});
               rd = (w >> bs) & m;
            end else begin
               push_t(1'b1, wr, 4'b0011, wd, {tag, " R10 low half"});
               push_t(1'b1, wr, 4'b1100, wd, {tag, " R10 high half"});
               rd = w;
            end
         end
         push_t(1'b0, 1'b1, 4'hF, 32'h0, {tag, " R4 address clear"});
         r.sts = 1'b0; r.data = wr ? 32'h0 : rd;
      end
      rsp_q.push_back(r);
      rtag_q.push_back(tag);
      req_write = wr; req_bus = bus; req_devfn = devfn; req_off = off;
      req_size = sz; req_wdata = wd; req_exclude = ex; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // bus slave and scoreboard monitor, all at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         mst_ready = stall_on ? ($urandom_range(0, 3) != 0) : 1'b1;
         if (mst_valid && mst_ready) begin
            got_t.win = mst_win; got_t.wr = mst_write; got_t.be = mst_be;
            got_t.data = mst_write ? (mst_wdata & bemask(mst_be)) : 32'h0;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected bus transfer", {25'b0, got_t}, 64'h0);
            end else begin
               exp_t = exp_q.pop_front();
               cur_tag = ttag_q.pop_front();
               chk(got_t == exp_t, cur_tag, {25'b0, got_t}, {25'b0, exp_t});
            end
            if (mst_write && !mst_win) slave_addr = bswap(mst_wdata);
         end
         mst_rdata = cfgw(slave_addr);
         if (done) begin
            chk(!req_ready && busy, "R1 ready low and busy high in done cycle",
                {62'b0, req_ready, busy}, 64'h1);
            got_r.sts = rsp_status; got_r.data = rsp_rdata;
            if (rsp_q.size() == 0) begin
               chk(1'b0, "R1 unexpected done", {31'b0, got_r}, 64'h0);
            end else begin
               exp_r = rsp_q.pop_front();
               cur_tag = rtag_q.pop_front();
               chk(got_r == exp_r, {cur_tag, " response"}, {31'b0, got_r}, {31'b0, exp_r});
            end
         end
      end else begin
         mst_ready = 1'b0;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog actual=hung expected=complete");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(req_ready && !busy && !done && !mst_valid, "R1 reset state",
          {60'b0, req_ready, busy, done, mst_valid}, 64'h8);
      rst_n = 1'b1;
      @(negedge clk);

      // bus 0: whole-word transfers
      issue(1'b0, 8'd0, 8'h08, 8'h10, 2'd2, 32'h0,          1'b0, "R7 read word");
      issue(1'b0, 8'd0, 8'h10, 8'h13, 2'd0, 32'h0,          1'b0, "R5 read byte lane3");
      issue(1'b0, 8'd0, 8'h11, 8'h22, 2'd1, 32'h0,          1'b0, "R5 read half upper");
      issue(1'b0, 8'd0, 8'h12, 8'h23, 2'd1, 32'h0,          1'b0, "R5 read half odd offset");
      issue(1'b1, 8'd0, 8'h20, 8'h04, 2'd2, 32'hA1B2_C3D4,  1'b0, "R7 write word");
      issue(1'b1, 8'd0, 8'h21, 8'h41, 2'd0, 32'hFFFF_FF5E,  1'b0, "R6 write byte");
      issue(1'b1, 8'd0, 8'h22, 8'h0E, 2'd1, 32'h1234_BEEF,  1'b0, "R6 write half");
      issue(1'b1, 8'd0, 8'h23, 8'h07, 2'd1, 32'h0000_7711,  1'b0, "R6 write half at lane3");
      // exclusion
      issue(1'b0, 8'd0, 8'h30, 8'h00, 2'd2, 32'h0,          1'b1, "R2 excluded read");
      issue(1'b1, 8'd4, 8'h31, 8'h08, 2'd0, 32'h55,         1'b1, "R2 excluded write");
      // other buses: narrow transfers
      issue(1'b0, 8'd3, 8'h40, 8'h05, 2'd0, 32'h0,          1'b0, "R8 read byte lane1");
      issue(1'b1, 8'd3, 8'h41, 8'h07, 2'd0, 32'h0000_00C7,  1'b0, "R8 write byte lane3");
      issue(1'b0, 8'd5, 8'h42, 8'h2A, 2'd1, 32'h0,          1'b0, "R9 read upper half");
      issue(1'b1, 8'd5, 8'h43, 8'h28, 2'd1, 32'h0000_9A8B,  1'b0, "R9 write lower half");
      issue(1'b1, 8'd5, 8'h44, 8'h2B, 2'd1, 32'h0000_4433,  1'b0, "R9 write upper half");
      issue(1'b0, 8'd7, 8'h50, 8'h3C, 2'd2, 32'h0,          1'b0, "R10 read split word");
      issue(1'b1, 8'd7, 8'h51, 8'h40, 2'd2, 32'hDEAD_F00D,  1'b0, "R10 write split word");
      // size code 3
      issue(1'b0, 8'd0, 8'h60, 8'h1B, 2'd3, 32'h0,          1'b0, "R11 size3 bus0 read");
      issue(1'b1, 8'd2, 8'h61, 8'h1C, 2'd3, 32'h0BAD_CAFE,  1'b0, "R11 size3 split write");

      // random stalls on the register port
      stall_on = 1'b1;
      for (int k = 0; k < 40; k++) begin
         issue(k[0], (k % 3 == 0) ? 8'd0 : 8'(k), 8'(k * 5), 8'(k * 7), 2'(k % 4),
               32'hC0DE_0000 + 32'(k) * 32'h0101_0101, (k % 11 == 5), "R12 stalled mix");
      end
      stall_on = 1'b0;

      for (int w = 0; w < 200 && (rsp_q.size() != 0 || exp_q.size() != 0 || busy); w++) begin
         @(negedge clk);
      end
      chk(exp_q.size() == 0 && rsp_q.size() == 0, "R12 all predicted activity seen",
          64'(exp_q.size() + rsp_q.size()), 64'h0);
      chk(req_ready && !busy && !mst_valid, "R1 idle at end",
          {61'b0, req_ready, busy, mst_valid}, 64'h4);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule